// File: doc/BRIEF.md
# Clock Pre-Divider with Bypass, Hold and Route Legality Check

This block sits between a source clock and a group of downstream channel dividers. It slows the source clock by an integer ratio from 1 to 6, chosen by a 3-bit code. It has two other modes. In bypass mode the source clock goes straight through. In hold mode the output stays low and has no edges. Bypass is a mode of its own and is not the same as the ratio-1 code. The ratio-1 code counts as an active stage, and that difference matters to the legality logic.

Next to the divider, a legality unit compares the stage setting with the bypass bit of each downstream channel. When the stage is active at ratio 1 and a channel divider is bypassed, that channel would get no usable clock, so the unit raises a per-channel flag. With the stage active, the total division seen by a channel is the stage ratio times the channel ratio (2 to 32). With the channel bypassed, the total is the stage ratio alone (2 to 6). With both the stage and the channel bypassed, the total is 1.

A new ratio code takes effect only when the current output period ends. The channel dividers therefore never see a shortened pulse.

Top module: `prediv_top`

## Requirements
- R1: Ratio code k, for k from 0 to 5, makes the divider output period k+1 source cycles.
- R2: For ratios of 2 or more, the output is high for floor(ratio/2) source cycles and low for the rest of the period. For ratio 1 (code 0), the output follows the source clock.
- R3: When `bypassEn` is 1 and `staticEn` is 0, `divClk` equals the source clock whatever the ratio code is. When bypass is on, every `chanIllegal` bit reads 0 after the next edge.
- R4: While `staticEn` is 1, `divClk` is 0, even in bypass. After `staticEn` returns to 0, the first rising source edge starts a fresh period with the output high, provided the ratio is 2 or more.
- R5: A ratio code change made in the middle of a period takes effect only after that period has run to its full old length.
- R6: Codes 6 and 7 are reserved and both divide by 6. One edge after such a code is applied, `cfgErr` reads 1. One edge after a code from 0 to 5 is applied, it reads 0.
- R7: One edge after the inputs are applied, `chanIllegal[i]` reads 1 exactly when `bypassEn` is 0, the ratio code is 0 and `chanBypass[i]` is 1. Otherwise it reads 0.
- R8: While `rstN` is low, `chanIllegal` and `cfgErr` are 0 and `divClk` is 0 (unless bypass is on). The first edge after release starts a period at the applied ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ratioSel | input | 3 | Ratio code (k gives k+1; 6 and 7 are reserved and give 6) |
| bypassEn | input | 1 | Routes the source clock around the stage |
| staticEn | input | 1 | Holds the output low |
| chanBypass | input | 4 | Bypass bit of each downstream channel divider |
| divClk | output | 1 | Stage output clock |
| chanIllegal | output | 4 | Per-channel flag for a combination that leaves the channel with no clock |
| cfgErr | output | 1 | Reserved ratio code in use |

## Verification
If the period counter or the held ratio is corrupted, the high/low run lengths of `divClk` change within one output period (at most six source cycles). A per-cycle reference comparison then catches it at the first wrong sample. If the deferred ratio load misbehaves, a period is cut short right at the point where the code changes. Errors in the legality flags or the reserved-code flag show one edge after the inputs are applied, and the bench sweeps every bypass combination to catch them.

// File: rtl/prediv_pkg.sv
package prediv_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 6;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   hold;       // force counter and output low
    logic   load;       // start a new period with loadRatio
    logic   parked;     // no period in progress
    ratio_t loadRatio;  // ratio for the next period
    ratio_t actRatio;   // ratio of the running period
  } divStrobe_t;
endpackage

// File: rtl/prediv_ctrl.sv
module prediv_ctrl
  import prediv_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    ratioSel,
  input  logic                bypassEn,
  input  logic                staticEn,
  input  logic [NUM_CHAN-1:0] chanBypass,
  input  logic                periodEnd,
  output divStrobe_t          strobe,
  output logic [NUM_CHAN-1:0] chanIllegal,
  output logic                cfgErr
);
  localparam int LAST_CODE = MAX_RATIO - 1;

  logic                reqReserved;
  ratio_t              reqRatio;
  ratio_t              actRatio;
  logic                parked;
  logic                unitCode;
  logic [NUM_CHAN-1:0] illegalNext;

  // decode requested ratio; reserved codes fall back to the maximum
  always_comb begin
    reqReserved = (int'(ratioSel) > LAST_CODE);
    if (reqReserved) reqRatio = ratio_t'(MAX_RATIO);
    else             reqRatio = ratio_t'(ratioSel) + ratio_t'(1);
  end

  // held ratio: reloaded only at a period boundary or on restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parked   <= 1'b1;
      actRatio <= ratio_t'(MAX_RATIO);
    end else if (staticEn) begin
      parked   <= 1'b1;
    end else if (parked || periodEnd) begin
      parked   <= 1'b0;
      actRatio <= reqRatio;
    end
  end

  always_comb begin
    strobe.hold      = staticEn;
    strobe.load      = !staticEn && (parked || periodEnd);
    strobe.parked    = parked;
    strobe.loadRatio = reqRatio;
    strobe.actRatio  = actRatio;
  end

  // legality: an active stage at ratio 1 cannot feed a bypassed channel
  assign unitCode = (ratioSel == '0);

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_legal
    assign illegalNext[ch] = !bypassEn && unitCode && chanBypass[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanIllegal <= '0;
      cfgErr      <= 1'b0;
    end else begin
      chanIllegal <= illegalNext;
      cfgErr      <= reqReserved;
    end
  end
endmodule

// File: rtl/prediv_datapath.sv
module prediv_datapath
  import prediv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  input  logic       bypassEn,
  input  logic       staticEn,
  output logic       periodEnd,
  output logic       divClk
);
  ratio_t cnt;
  ratio_t cntInc;
  ratio_t actHalf;
  ratio_t loadHalf;
  logic   phaseQ;

  assign cntInc   = cnt + ratio_t'(1);
  assign actHalf  = strobe.actRatio >> 1;
  assign loadHalf = strobe.loadRatio >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
    end else if (strobe.hold) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
    end else if (strobe.load) begin
      cnt    <= '0;
      phaseQ <= (loadHalf != '0);
    end else begin
      cnt    <= cntInc;
      phaseQ <= (cntInc < actHalf);
    end
  end

  assign periodEnd = !strobe.parked && (cnt == strobe.actRatio - ratio_t'(1));

  // output select: hold beats bypass; ratio 1 passes the source through
  always_comb begin
    if (staticEn)                            divClk = 1'b0;
    else if (bypassEn)                       divClk = clk;
    else if (strobe.parked)                  divClk = 1'b0;
    else if (strobe.actRatio == ratio_t'(1)) divClk = clk;
    else                                     divClk = phaseQ;
  end
endmodule

// File: rtl/prediv_top.sv
module prediv_top
  import prediv_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    ratioSel,
  input  logic                bypassEn,
  input  logic                staticEn,
  input  logic [NUM_CHAN-1:0] chanBypass,
  output logic                divClk,
  output logic [NUM_CHAN-1:0] chanIllegal,
  output logic                cfgErr
);
  divStrobe_t strobe;
  logic       periodEnd;

  prediv_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ratioSel   (ratioSel),
    .bypassEn   (bypassEn),
    .staticEn   (staticEn),
    .chanBypass (chanBypass),
    .periodEnd  (periodEnd),
    .strobe     (strobe),
    .chanIllegal(chanIllegal),
    .cfgErr     (cfgErr)
  );

  prediv_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bypassEn (bypassEn),
    .staticEn (staticEn),
    .periodEnd(periodEnd),
    .divClk   (divClk)
  );
endmodule

// File: rtl/prediv_checker.sv
module prediv_checker
  import prediv_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SEL_W-1:0]    ratioSel,
  input logic                bypassEn,
  input logic                staticEn,
  input logic [NUM_CHAN-1:0] chanBypass,
  input logic                divClk,
  input logic [NUM_CHAN-1:0] chanIllegal,
  input logic                cfgErr
);
  assert_static_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    staticEn |-> !divClk);

  assert_reserved_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(ratioSel) >= MAX_RATIO) |=> cfgErr);

  assert_legal_code_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(ratioSel) < MAX_RATIO) |=> !cfgErr);

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassEn && ratioSel == '0) |=> (chanIllegal == $past(chanBypass)));

  assert_bypass_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    bypassEn |=> (chanIllegal == '0));
endmodule

bind prediv_top prediv_checker #(.NUM_CHAN(NUM_CHAN)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ratioSel   (ratioSel),
  .bypassEn   (bypassEn),
  .staticEn   (staticEn),
  .chanBypass (chanBypass),
  .divClk     (divClk),
  .chanIllegal(chanIllegal),
  .cfgErr     (cfgErr)
);

// File: tb/prediv_top_test.sv
`timescale 1ns/1ps
module prediv_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] ratioSel = 3'd1;
  logic       bypassEn = 1'b0;
  logic       staticEn = 1'b0;
  logic [3:0] chanBypass = 4'd0;
  logic       divClk;
  logic [3:0] chanIllegal;
  logic       cfgErr;

  int checks = 0;
  int fails = 0;
  string curReq = "R8";

  // reference model state
  int mCnt = 0, mAct = 6, mPark = 1, mQ = 0, mErr = 0;
  logic [3:0] mIll = 4'd0;
  // run-length tracking of the high-phase samples
  int runLen = 0, lastHighRun = 0, lastLowRun = 0;
  logic prevHi = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prediv_top uut (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .bypassEn(bypassEn),
    .staticEn(staticEn), .chanBypass(chanBypass), .divClk(divClk),
    .chanIllegal(chanIllegal), .cfgErr(cfgErr)
  );

  function automatic int ratioOf(int code);
    return (code >= 6) ? 6 : code + 1;
  endfunction

  function automatic logic expOut(logic phase);
    if (staticEn) return 1'b0;
    if (bypassEn) return phase;
    if (mPark != 0) return 1'b0;
    if (mAct == 1) return phase;
    return mQ[0];
  endfunction

  task automatic checkVal(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each rising edge, compare shortly after
  always @(posedge clk) begin
    if (!rstN) begin
      mPark = 1; mQ = 0; mCnt = 0; mErr = 0; mIll = 4'd0;
    end else begin
      mErr = (ratioSel >= 3'd6) ? 1 : 0;
      for (int ch = 0; ch < 4; ch++)
        mIll[ch] = !bypassEn && (ratioSel == 3'd0) && chanBypass[ch];
      if (staticEn) begin
        mPark = 1; mQ = 0; mCnt = 0;
      end else if (mPark != 0 || mCnt == mAct - 1) begin
        mPark = 0; mCnt = 0; mAct = ratioOf(int'(ratioSel));
        mQ = (mAct / 2 > 0) ? 1 : 0;
      end else begin
        mCnt++;
        mQ = (mCnt < mAct / 2) ? 1 : 0;
      end
    end
    #1;
    checkVal({curReq, " divClk high phase"}, int'(divClk), int'(expOut(1'b1)));
    checkVal({curReq, " chanIllegal"}, int'(chanIllegal), int'(mIll));
    checkVal({curReq, " cfgErr"}, int'(cfgErr), mErr);
    if (divClk == prevHi) runLen++;
    else begin
      if (prevHi) lastHighRun = runLen; else lastLowRun = runLen;
      runLen = 1;
    end
    prevHi = divClk;
  end

  always @(negedge clk) begin
    #1;
    checkVal({curReq, " divClk low phase"}, int'(divClk), int'(expOut(1'b0)));
  end

  task automatic setCfg(int sel, logic byp, logic stat, logic [3:0] cb);
    @(negedge clk); #1.5;
    ratioSel = 3'(sel); bypassEn = byp; staticEn = stat; chanBypass = cb;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1.5;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R8: reset state
    waitCyc(4);
    checkVal("R8 divClk in reset", int'(divClk), 0);
    checkVal("R8 chanIllegal in reset", int'(chanIllegal), 0);
    checkVal("R8 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkVal("R8 first period starts high", int'(divClk), 1);

    // R1/R2/R6: every ratio code
    for (int code = 0; code < 8; code++) begin
      curReq = (code >= 6) ? "R6" : "R1";
      setCfg(code, 1'b0, 1'b0, 4'd0);
      waitCyc(30);
      if (code == 0) begin
        @(posedge clk); #1;
        checkVal("R2 ratio1 high phase", int'(divClk), 1);
        @(negedge clk); #1;
        checkVal("R2 ratio1 low phase", int'(divClk), 0);
      end else begin
        checkVal("R2 high run", lastHighRun, ratioOf(code) / 2);
        checkVal("R1 low run", lastLowRun, ratioOf(code) - ratioOf(code) / 2);
      end
      checkVal("R6 cfgErr", int'(cfgErr), (code >= 6) ? 1 : 0);
    end

    // R7: every stage/channel bypass combination at codes 0 and 1
    curReq = "R7";
    for (int byp = 0; byp < 2; byp++)
      for (int cb = 0; cb < 16; cb++)
        for (int code = 0; code < 2; code++) begin
          setCfg(code, 1'(byp), 1'b0, 4'(cb));
          waitCyc(1);
          checkVal("R7 chanIllegal", int'(chanIllegal),
                   (byp == 0 && code == 0) ? cb : 0);
        end

    // R3: bypass follows the source clock at a non-unit ratio
    curReq = "R3";
    setCfg(3, 1'b1, 1'b0, 4'hF);
    waitCyc(3);
    @(posedge clk); #1;
    checkVal("R3 bypass high phase", int'(divClk), 1);
    @(negedge clk); #1;
    checkVal("R3 bypass low phase", int'(divClk), 0);
    checkVal("R3 bypass no flags", int'(chanIllegal), 0);

    // R4: hold overrides bypass, then restarts a fresh period
    curReq = "R4";
    setCfg(3, 1'b1, 1'b1, 4'd0);
    @(posedge clk); #1;
    checkVal("R4 hold in bypass", int'(divClk), 0);
    setCfg(3, 1'b0, 1'b1, 4'd0);
    waitCyc(5);
    checkVal("R4 hold low", int'(divClk), 0);
    setCfg(3, 1'b0, 1'b0, 4'd0);
    @(posedge clk); #1;
    checkVal("R4 restart high", int'(divClk), 1);

    // R5: mid-period change from 6 to 2
    curReq = "R5";
    setCfg(5, 1'b0, 1'b0, 4'd0);
    waitCyc(20);
    while (!(divClk && runLen == 1)) @(posedge clk) #1.2;
    setCfg(1, 1'b0, 1'b0, 4'd0);
    while (divClk) @(posedge clk) #1.2;
    while (!divClk) @(posedge clk) #1.2;
    checkVal("R5 old high run kept", lastHighRun, 3);
    checkVal("R5 old low run kept", lastLowRun, 3);
    waitCyc(10);
    checkVal("R5 new high run", lastHighRun, 1);
    checkVal("R5 new low run", lastLowRun, 1);

    summary();
  end
endmodule